// File: doc/BRIEF.md
# Sigma-Delta Modulator Overload Detector

This block watches the raw symbol stream leaving an oversampled sigma-delta modulator on two receive channels and reports when the modulator is being driven into overload. An overloaded modulator falls behind its input and emits its extreme codes far more often than usual. The block therefore measures the density of those codes rather than testing a clip level. Each accepted symbol is squared and summed over a window whose length software sets. When the window closes, the sum is compared against two thresholds, one large and one small.

Both channels use the same window length and the same two thresholds. Each channel keeps its own window count, its own running sum, its own pair of flags and its own copy of the last completed window sum. The flags change only when a window closes and hold their value until the channel's next window closes.

A mode input decides whether the flags also appear on a set of monitor outputs. In manual gain mode an external processor watches those outputs. In automatic mode the monitor outputs stay low.

Top module: `sd_overload_detector`

## Requirements
- R1: Each symbol is a 4-bit two's-complement value with a legal range of -4..+4. Before squaring, codes +5..+7 are treated as +4 and codes -8..-5 are treated as -4, so every square lies in 0..16.
- R2: A window on a channel closes on the strobe that brings its count of accepted symbols (those with the strobe high) up to the effective length. The effective length is `win_len`, with 0 read as 1 and any value above 256 read as 256. It is sampled on every strobe.
- R3: The running sum never exceeds 256 x 16 = 4096, so 13 bits always hold it.
- R4: In the cycle after a window closes, `ovl_big` for that channel is 1 exactly when the window sum is strictly greater than `thr_big`.
- R5: In the same cycle, `ovl_small` is 1 exactly when the window sum is strictly greater than `thr_small`. This holds even when `thr_small` is above `thr_big`.
- R6: Between window closes, a channel's flags and its `last_sum` hold their values.
- R7: Both channels use the shared thresholds and window length. Activity on one channel never changes the other channel's outputs.
- R8: `mon_big` and `mon_small` equal the flags while `manual_mode` is 1 and are all zero while it is 0.
- R9: A synchronous reset clears every running sum, window count, flag and `last_sum`.
- R10: `last_sum` for a channel (13 bits per channel, channel 0 in the low bits) shows the completed window sum in the same cycle as its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld | input | 2 | Per-channel symbol strobe |
| sample_data | input | 8 | Per-channel 4-bit signed symbol, channel 0 in bits 3:0 |
| win_len | input | 9 | Window length in symbols |
| thr_big | input | 13 | Large threshold, shared |
| thr_small | input | 13 | Small threshold, shared |
| manual_mode | input | 1 | 1 routes the flags to the monitor outputs |
| ovl_big | output | 2 | Per-channel large-threshold flag |
| ovl_small | output | 2 | Per-channel small-threshold flag |
| mon_big | output | 2 | Large flags as seen on the monitor outputs |
| mon_small | output | 2 | Small flags as seen on the monitor outputs |
| last_sum | output | 26 | Per-channel last completed window sum |

## Verification
The properties assume that the thresholds are steady in the cycle in which a window closes, because the compare is checked against the previous cycle's threshold value. The stimulus changes the thresholds and the window length only between bursts and never on a closing strobe. The symbol inputs are unconstrained, and the stimulus sends out-of-range codes on purpose to exercise the saturation in R1. The no-overflow property does depend on the effective-length clamp, so the stimulus includes lengths of 0 and lengths above 256.

// File: rtl/sdod_pkg.sv
package sdod_pkg;
  localparam int SYM_W   = 4;
  localparam int SYM_LIM = 4;
  localparam int SQ_W    = 5;

  // Saturate a symbol to the legal range and square it.
  function automatic logic [SQ_W-1:0] sym_square(input logic signed [SYM_W-1:0] s);
    logic [2:0] mag;
    if (s > 4'sd4)       mag = 3'd4;
    else if (s < -4'sd4) mag = 3'd4;
    else if (s < 0)      mag = 3'(-s);
    else                 mag = 3'(s);
    return SQ_W'(mag * mag);
  endfunction

  // Map the programmed length to the usable range 1..lim.
  function automatic int unsigned eff_length(input int unsigned len, input int unsigned lim);
    if (len == 0)  return 1;
    if (len > lim) return lim;
    return len;
  endfunction
endpackage

// File: rtl/sdod_sym_square.sv
module sdod_sym_square
  import sdod_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  output logic [SQ_W-1:0]  sq
);
  always_comb sq = sym_square(sym);
endmodule

// File: rtl/sdod_window_acc.sv
module sdod_window_acc
  import sdod_pkg::*;
#(
  parameter int WIN_MAX = 256,
  localparam int LEN_W  = $clog2(WIN_MAX) + 1,
  localparam int ACC_W  = $clog2(WIN_MAX * 16 + 1)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [SQ_W-1:0]  sq,
  input  logic [LEN_W-1:0] len_eff,
  output logic             win_end,
  output logic [ACC_W-1:0] win_sum,
  output logic [ACC_W-1:0] acc_q
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_next;

  always_comb begin
    cnt_next = cnt_q + LEN_W'(1);
    win_end  = vld && (cnt_next >= len_eff);
    win_sum  = acc_q + ACC_W'(sq);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (vld) begin
      if (win_end) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else begin
        cnt_q <= cnt_next;
        acc_q <= win_sum;
      end
    end
  end
endmodule

// File: rtl/sdod_thresh_cmp.sv
module sdod_thresh_cmp #(
  parameter int ACC_W = 13
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             win_end,
  input  logic [ACC_W-1:0] win_sum,
  input  logic [ACC_W-1:0] thr_big,
  input  logic [ACC_W-1:0] thr_small,
  output logic             flag_big,
  output logic             flag_small,
  output logic [ACC_W-1:0] sum_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_big   <= 1'b0;
      flag_small <= 1'b0;
      sum_q      <= '0;
    end else if (win_end) begin
      flag_big   <= (win_sum > thr_big);
      flag_small <= (win_sum > thr_small);
      sum_q      <= win_sum;
    end
  end
endmodule

// File: rtl/sd_overload_detector.sv
module sd_overload_detector
  import sdod_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int WIN_MAX = 256,
  localparam int LEN_W  = $clog2(WIN_MAX) + 1,
  localparam int ACC_W  = $clog2(WIN_MAX * 16 + 1)
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       sample_vld,
  input  logic [NUM_CH*SYM_W-1:0] sample_data,
  input  logic [LEN_W-1:0]        win_len,
  input  logic [ACC_W-1:0]        thr_big,
  input  logic [ACC_W-1:0]        thr_small,
  input  logic                    manual_mode,
  output logic [NUM_CH-1:0]       ovl_big,
  output logic [NUM_CH-1:0]       ovl_small,
  output logic [NUM_CH-1:0]       mon_big,
  output logic [NUM_CH-1:0]       mon_small,
  output logic [NUM_CH*ACC_W-1:0] last_sum
);
  logic [LEN_W-1:0]        len_eff;
  logic [NUM_CH-1:0]       win_end;
  logic [NUM_CH*ACC_W-1:0] acc_bus;

  always_comb len_eff = LEN_W'(eff_length(int'(win_len), WIN_MAX));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SQ_W-1:0]  sq;
    logic [ACC_W-1:0] win_sum;

    sdod_sym_square u_sq (
      .sym (sample_data[c*SYM_W +: SYM_W]),
      .sq  (sq)
    );

    sdod_window_acc #(.WIN_MAX(WIN_MAX)) u_win (
      .clk     (clk),
      .rst     (rst),
      .vld     (sample_vld[c]),
      .sq      (sq),
      .len_eff (len_eff),
      .win_end (win_end[c]),
      .win_sum (win_sum),
      .acc_q   (acc_bus[c*ACC_W +: ACC_W])
    );

    sdod_thresh_cmp #(.ACC_W(ACC_W)) u_cmp (
      .clk        (clk),
      .rst        (rst),
      .win_end    (win_end[c]),
      .win_sum    (win_sum),
      .thr_big    (thr_big),
      .thr_small  (thr_small),
      .flag_big   (ovl_big[c]),
      .flag_small (ovl_small[c]),
      .sum_q      (last_sum[c*ACC_W +: ACC_W])
    );
  end

  always_comb begin
    mon_big   = manual_mode ? ovl_big   : '0;
    mon_small = manual_mode ? ovl_small : '0;
  end
endmodule

// File: rtl/sdod_checker.sv
module sdod_checker #(
  parameter int NUM_CH  = 2,
  parameter int WIN_MAX = 256,
  parameter int ACC_W   = 13
)(
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH-1:0]       win_end,
  input logic [NUM_CH*ACC_W-1:0] acc_bus,
  input logic [ACC_W-1:0]        thr_big,
  input logic [ACC_W-1:0]        thr_small,
  input logic [NUM_CH-1:0]       ovl_big,
  input logic [NUM_CH-1:0]       ovl_small,
  input logic [NUM_CH*ACC_W-1:0] last_sum
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      acc_bus[c*ACC_W +: ACC_W] <= ACC_W'(WIN_MAX * 16));

    p_big_cmp_r4: assert property (@(posedge clk) disable iff (rst)
      win_end[c] |=> (ovl_big[c] == (last_sum[c*ACC_W +: ACC_W] > $past(thr_big))));

    p_small_cmp_r5: assert property (@(posedge clk) disable iff (rst)
      win_end[c] |=> (ovl_small[c] == (last_sum[c*ACC_W +: ACC_W] > $past(thr_small))));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !win_end[c] |=> ($stable(ovl_big[c]) && $stable(ovl_small[c])
                       && $stable(last_sum[c*ACC_W +: ACC_W])));
  end
endmodule

bind sd_overload_detector sdod_checker #(
  .NUM_CH  (NUM_CH),
  .WIN_MAX (WIN_MAX),
  .ACC_W   (ACC_W)
) u_sdod_chk (
  .clk       (clk),
  .rst       (rst),
  .win_end   (win_end),
  .acc_bus   (acc_bus),
  .thr_big   (thr_big),
  .thr_small (thr_small),
  .ovl_big   (ovl_big),
  .ovl_small (ovl_small),
  .last_sum  (last_sum)
);

// File: tb/tb_sd_overload_detector.sv
`timescale 1ns/1ps
module tb_sd_overload_detector;
  localparam int NCH = 2;
  localparam int AW  = 13;

  logic           clk = 1'b0;
  logic           rst;
  logic [NCH-1:0] sample_vld;
  logic [7:0]     sample_data;
  logic [8:0]     win_len;
  logic [AW-1:0]  thr_big, thr_small;
  logic           manual_mode;
  logic [NCH-1:0] ovl_big, ovl_small, mon_big, mon_small;
  logic [2*AW-1:0] last_sum;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  int m_acc [NCH];
  int m_cnt [NCH];
  bit e_big [NCH];
  bit e_small [NCH];
  int e_sum [NCH];

  always #4 clk = ~clk;

  sd_overload_detector dut (
    .clk(clk), .rst(rst), .sample_vld(sample_vld), .sample_data(sample_data),
    .win_len(win_len), .thr_big(thr_big), .thr_small(thr_small),
    .manual_mode(manual_mode), .ovl_big(ovl_big), .ovl_small(ovl_small),
    .mon_big(mon_big), .mon_small(mon_small), .last_sum(last_sum)
  );

  function automatic int ref_sq(input logic [3:0] code);
    int v = (code >= 8) ? int'(code) - 16 : int'(code);
    if (v > 4) v = 4;
    if (v < -4) v = -4;
    return v * v;
  endfunction

  function automatic int ref_len(input int l);
    return (l < 1) ? 1 : ((l > 256) ? 256 : l);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model; tag "" selects per-field tags.
  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk(tag == "" ? "R4"  : tag, int'(ovl_big[c]),   int'(e_big[c]));
      chk(tag == "" ? "R5"  : tag, int'(ovl_small[c]), int'(e_small[c]));
      chk(tag == "" ? "R10" : tag, int'(last_sum[c*AW +: AW]), e_sum[c]);
      chk(tag == "" ? "R8"  : tag, int'(mon_big[c]),   manual_mode ? int'(e_big[c]) : 0);
      chk(tag == "" ? "R8"  : tag, int'(mon_small[c]), manual_mode ? int'(e_small[c]) : 0);
    end
  endtask

  // Apply inputs for one edge (called at negedge), update model, check after edge.
  task automatic step(input logic [1:0] v, input logic [7:0] d, input string tag);
    sample_vld  = v;
    sample_data = d;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_acc[c] = 0; m_cnt[c] = 0; e_big[c] = 0; e_small[c] = 0; e_sum[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) if (v[c]) begin
        int s = ref_sq(d[c*4 +: 4]);
        if (m_cnt[c] + 1 >= ref_len(int'(win_len))) begin
          e_sum[c]   = m_acc[c] + s;
          e_big[c]   = e_sum[c] > int'(thr_big);
          e_small[c] = e_sum[c] > int'(thr_small);
          m_acc[c] = 0; m_cnt[c] = 0;
        end else begin
          m_acc[c] += s; m_cnt[c]++;
        end
      end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(2'b00, 8'h00, tag);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; sample_vld = '0; sample_data = '0; win_len = 9'd4;
    thr_big = 13'd40; thr_small = 13'd10; manual_mode = 1'b1;
    @(negedge clk);
    step(2'b11, 8'h44, "R9");
    step(2'b11, 8'h44, "R9");
    rst = 1'b0;

    // R1: saturation of out-of-range codes, window of 1
    win_len = 9'd1; thr_big = 13'd15; thr_small = 13'd0;
    step(2'b01, 8'h07, "R1");      // +7 -> 16
    step(2'b01, 8'h08, "R1");      // -8 -> 16
    step(2'b01, 8'h0D, "R1");      // -3 -> 9
    // R4: strict compare at equality
    thr_big = 13'd16;
    step(2'b01, 8'h04, "R4");
    thr_big = 13'd15;
    step(2'b01, 8'h0C, "R4");      // -4 -> 16 > 15
    // R2: length 0 acts as 1
    win_len = 9'd0;
    step(2'b10, 8'h20, "R2");
    // R7: channel 1 windows do not touch channel 0
    win_len = 9'd3;
    step(2'b10, 8'h40, "R7");
    step(2'b10, 8'h40, "R7");
    step(2'b10, 8'h40, "R7");
    // R6: hold during idle and during a partial window
    idle(5, "R6");
    step(2'b01, 8'h04, "R6");
    step(2'b01, 8'h04, "R6");
    step(2'b01, 8'h04, "R6");
    // R5: small above big still evaluated on its own
    thr_big = 13'd20; thr_small = 13'd100;
    win_len = 9'd2;
    step(2'b11, 8'hCC, "R5");
    step(2'b11, 8'hCC, "R5");
    // R8: monitor gating
    manual_mode = 1'b0;
    idle(2, "R8");
    manual_mode = 1'b1;
    idle(1, "R8");
    // R3: longest window at full scale, length above range clamps to 256
    win_len = 9'd400; thr_big = 13'd4095; thr_small = 13'd4000;
    for (int i = 0; i < 256; i++) step(2'b11, (i % 2) ? 8'h4C : 8'hC4, "R3");
    idle(1, "R3");

    // constrained random bursts
    for (int b = 0; b < 60; b++) begin
      win_len   = 9'($urandom_range(0, 300));
      thr_big   = 13'($urandom_range(0, 4200));
      thr_small = 13'($urandom_range(0, 4200));
      manual_mode = 1'($urandom_range(0, 1));
      for (int i = 0; i < 400; i++)
        step(2'($urandom_range(0, 3)), 8'($urandom), "");
      // drain: flush open windows before the next reprogramming
      for (int i = 0; i < 300; i++) step(2'b11, 8'($urandom), "");
    end

    // R9: mid-run reset clears everything
    step(2'b11, 8'h44, "R9");
    rst = 1'b1;
    step(2'b11, 8'h44, "R9");
    rst = 1'b0;
    idle(2, "R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8ns * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule